// File: doc/BRIEF.md
# Sticky Interrupt Status Register

This block holds the interrupt status for a keypad-scanning controller. Six event sources feed it: key events, general-purpose inputs, keypad lock, event overflow and two comparators. Each source that fires sets its own sticky status bit. The host clears a bit by writing 1 to that bit position. The key-event bit and the GPI bit refuse that clear for as long as their underlying condition is still present.

The block drives one active-low interrupt line to the processor. That line is gated by a per-source enable and by a global mask. The key-event, GPI and overflow bits latch only when their source is enabled, and they latch whether or not the global mask is on. The keylock and comparator bits latch on every pulse. The host sees the status as an 8-bit read word.

Top module: `key_isr_reg`

## Requirements
- R1: A synchronous active-high reset clears all status bits to 0 and drives `irq_n` high (inactive).
- R2: The status word places the sources as follows: bit 0 key events, bit 1 GPI, bit 2 keypad lock, bit 3 overflow, bit 4 comparator 1, bit 5 comparator 2. Bits 7 and 6 always read 0.
- R3: A status bit that has been set stays at 1 until a write-1 clear takes effect on it.
- R4: A write with `wr_data` bit i = 1 clears status bit i at the next clock edge. A write with bit i = 0 leaves bit i unchanged.
- R5: Status bit 0 does not clear while `fifo_nonempty` is 1, even when the host writes 1 to it.
- R6: Status bit 1 does not clear while `gpi_pending` is 1, even when the host writes 1 to it.
- R7: Bits 0, 1 and 3 latch a pulse only when the matching `src_en` bit is 1. When enabled, they latch even while `irq_mask` is 1.
- R8: Bits 2, 4 and 5 latch a pulse whatever the state of `src_en`.
- R9: If a set pulse and a write-1 clear hit the same bit in the same cycle, the bit ends up set.
- R10: `irq_n` is registered. After each clock edge it is 0 exactly when, in the previous cycle, some status bit and its `src_en` bit were both 1 and `irq_mask` was 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_pulse | input | 6 | One-cycle event pulses, indexed by status bit position |
| fifo_nonempty | input | 1 | Key event queue holds entries (holds bit 0) |
| gpi_pending | input | 1 | GPI interrupt condition still unresolved (holds bit 1) |
| src_en | input | 6 | Per-source enables, indexed by status bit position |
| irq_mask | input | 1 | Global mask of the processor interrupt |
| wr_en | input | 1 | Host write strobe to the status register |
| wr_data | input | 8 | Host write data, 1 bits request a clear |
| rd_data | output | 8 | Status word as the host reads it |
| irq_n | output | 1 | Active-low processor interrupt |

## Verification
Directed phases each isolate one behaviour:
- a disabled pulse against an enabled one on the gated bits;
- pulses while the mask is on;
- zero writes against one writes;
- clears held back by a raised `fifo_nonempty` or `gpi_pending`;
- a pulse that lands in the same cycle as its clear.

These phases tell gating apart from masking, and a hold apart from a plain refusal to clear. A long stretch of random pulses, enables, holds and writes then compares every cycle against a behavioural model. This catches any bit whose set, clear or interrupt term strays from its neighbours.

// File: rtl/isr_pkg.sv
package isr_pkg;
  localparam int NSRC = 6;
  localparam int DW   = 8;
  localparam int B_KEY  = 0;
  localparam int B_GPI  = 1;
  localparam int B_LOCK = 2;
  localparam int B_OVF  = 3;
  localparam int B_CMP1 = 4;
  localparam int B_CMP2 = 5;
  // sources whose status latches only when enabled
  localparam logic [NSRC-1:0] GATED_SET = (NSRC'(1) << B_KEY) | (NSRC'(1) << B_GPI) | (NSRC'(1) << B_OVF);
  // sources whose clear is refused while a condition holds
  localparam logic [NSRC-1:0] HOLDABLE  = (NSRC'(1) << B_KEY) | (NSRC'(1) << B_GPI);
endpackage

// File: rtl/isr_cell.sv
module isr_cell #(
  parameter bit GATED = 1'b0,
  parameter bit HOLDS = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic set_pulse,
  input  logic enable,
  input  logic hold,
  input  logic clr_req,
  output logic stat_q
);
  logic set_eff, clr_eff;

  generate
    if (GATED) begin : g_gated
      assign set_eff = set_pulse & enable;
    end else begin : g_free
      assign set_eff = set_pulse;
    end
    if (HOLDS) begin : g_hold
      assign clr_eff = clr_req & ~hold;
    end else begin : g_nohold
      assign clr_eff = clr_req;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)           stat_q <= 1'b0;
    else if (set_eff)  stat_q <= 1'b1;
    else if (clr_eff)  stat_q <= 1'b0;
  end
endmodule

// File: rtl/isr_irq_gen.sv
module isr_irq_gen #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] stat,
  input  logic [N-1:0] enable,
  input  logic         mask,
  output logic         irq_n
);
  logic any_live;
  assign any_live = |(stat & enable);

  always_ff @(posedge clk) begin
    if (rst) irq_n <= 1'b1;
    else     irq_n <= ~(any_live & ~mask);
  end
endmodule

// File: rtl/key_isr_reg.sv
module key_isr_reg
  import isr_pkg::*;
#(
  parameter int NS = NSRC,
  parameter int W  = DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NS-1:0] src_pulse,
  input  logic          fifo_nonempty,
  input  logic          gpi_pending,
  input  logic [NS-1:0] src_en,
  input  logic          irq_mask,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  output logic [W-1:0]  rd_data,
  output logic          irq_n
);
  localparam int PAD = W - NS;

  logic [NS-1:0] stat;
  logic [NS-1:0] hold_vec;
  logic [NS-1:0] clr_vec;

  always_comb begin
    hold_vec        = '0;
    hold_vec[B_KEY] = fifo_nonempty;
    hold_vec[B_GPI] = gpi_pending;
    clr_vec         = wr_en ? wr_data[NS-1:0] : '0;
  end

  for (genvar i = 0; i < NS; i++) begin : g_bit
    isr_cell #(
      .GATED (GATED_SET[i]),
      .HOLDS (HOLDABLE[i])
    ) u_cell (
      .clk       (clk),
      .rst       (rst),
      .set_pulse (src_pulse[i]),
      .enable    (src_en[i]),
      .hold      (hold_vec[i]),
      .clr_req   (clr_vec[i]),
      .stat_q    (stat[i])
    );
  end

  isr_irq_gen #(.N(NS)) u_irq (
    .clk    (clk),
    .rst    (rst),
    .stat   (stat),
    .enable (src_en),
    .mask   (irq_mask),
    .irq_n  (irq_n)
  );

  assign rd_data = {{PAD{1'b0}}, stat};
endmodule

// File: rtl/key_isr_reg_chk.sv
module key_isr_reg_chk (
  input logic       clk,
  input logic       rst,
  input logic [5:0] src_pulse,
  input logic       fifo_nonempty,
  input logic       gpi_pending,
  input logic [5:0] src_en,
  input logic       irq_mask,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       irq_n
);
  logic [5:0] clr_now;
  assign clr_now = wr_en ? wr_data[5:0] : 6'd0;

  // R2
  a_r2_upper_zero: assert property (@(posedge clk) disable iff (rst)
    rd_data[7:6] == 2'b00);

  // R3
  a_r3_sticky: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((($past(rd_data[5:0]) & ~$past(clr_now)) & ~rd_data[5:0]) == 6'd0));

  // R5
  a_r5_fifo_hold: assert property (@(posedge clk) disable iff (rst)
    (rd_data[0] && fifo_nonempty) |=> rd_data[0]);

  // R6
  a_r6_gpi_hold: assert property (@(posedge clk) disable iff (rst)
    (rd_data[1] && gpi_pending) |=> rd_data[1]);

  // R9 (ungated bits) and R8
  a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
    (src_pulse[4] && clr_now[4]) |=> rd_data[4]);

  // R7
  a_r7_gated_off: assert property (@(posedge clk) disable iff (rst)
    (!rd_data[3] && src_pulse[3] && !src_en[3]) |=> !rd_data[3]);

  // R10
  a_r10_irq: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_n == !((|($past(rd_data[5:0]) & $past(src_en))) && !$past(irq_mask))));
endmodule

bind key_isr_reg key_isr_reg_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .src_pulse     (src_pulse),
  .fifo_nonempty (fifo_nonempty),
  .gpi_pending   (gpi_pending),
  .src_en        (src_en),
  .irq_mask      (irq_mask),
  .wr_en         (wr_en),
  .wr_data       (wr_data),
  .rd_data       (rd_data),
  .irq_n         (irq_n)
);

// File: tb/key_isr_reg_bench.sv
module key_isr_reg_bench;
  logic       clk = 1'b0;
  logic       rst;
  logic [5:0] src_pulse;
  logic       fifo_nonempty, gpi_pending;
  logic [5:0] src_en;
  logic       irq_mask, wr_en;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic       irq_n;

  int n_chk = 0, n_bad = 0;
  string tag = "R1";
  bit [5:0] m_stat;
  bit       m_irq_n;
  bit       done = 0;

  always #2 clk = ~clk;

  key_isr_reg u_key_isr_reg (
    .clk(clk), .rst(rst), .src_pulse(src_pulse), .fifo_nonempty(fifo_nonempty),
    .gpi_pending(gpi_pending), .src_en(src_en), .irq_mask(irq_mask),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .irq_n(irq_n)
  );

  task automatic check(input string t, input logic [8:0] act, input logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", t, act, exp);
    end
  endtask

  // one clock: model update at the edge, compare at the following falling edge
  task automatic step();
    bit [5:0] gate, hold, clr, seteff;
    @(posedge clk);
    gate = 6'b001011;
    hold = {4'b0, gpi_pending, fifo_nonempty};
    clr  = wr_en ? wr_data[5:0] : 6'd0;
    seteff = src_pulse & (src_en | ~gate);
    if (rst) begin
      m_stat = '0; m_irq_n = 1'b1;
    end else begin
      m_irq_n = !((|(m_stat & src_en)) && !irq_mask);
      m_stat  = (m_stat & ~(clr & ~hold)) | seteff;
    end
    @(negedge clk);
    check(tag, {irq_n, rd_data}, {m_irq_n, 2'b00, m_stat});
  endtask

  task automatic idle();
    src_pulse = '0; wr_en = 0; wr_data = '0;
  endtask

  initial begin
    rst = 1; idle(); fifo_nonempty = 0; gpi_pending = 0; src_en = '0; irq_mask = 0;
    m_stat = '0; m_irq_n = 1;
    tag = "R1"; step(); step();
    rst = 0; step();
    // R7: gated bits ignore disabled pulses, R8: ungated bits latch anyway
    tag = "R7"; src_pulse = 6'b111111; step(); idle(); step();
    tag = "R8"; check("R8", {1'b0, rd_data}, 9'h034);
    // R4: write zero no effect, write one clears
    tag = "R4"; wr_en = 1; wr_data = 8'h00; step(); idle(); step();
    wr_en = 1; wr_data = 8'h3F; step(); idle(); step();
    // R7: enabled and masked still latch; R10 irq stays high under mask
    tag = "R7"; src_en = 6'b111111; irq_mask = 1; src_pulse = 6'b001011; step(); idle(); step(); step();
    tag = "R10"; irq_mask = 0; step(); step();
    // R5: fifo holds bit 0
    tag = "R5"; fifo_nonempty = 1; wr_en = 1; wr_data = 8'hFF; step(); idle(); step();
    // R6: gpi holds bit 1
    tag = "R6"; fifo_nonempty = 0; gpi_pending = 1; wr_en = 1; wr_data = 8'h03; step(); idle(); step();
    gpi_pending = 0; wr_en = 1; wr_data = 8'h02; step(); idle(); step();
    // R9: set wins over clear
    tag = "R9"; src_pulse = 6'b110000; wr_en = 1; wr_data = 8'h30; step(); idle(); step();
    // R3: sticky
    tag = "R3"; for (int i = 0; i < 5; i++) step();
    // random mix, R2 upper bits checked each cycle
    tag = "R2";
    for (int i = 0; i < 2000; i++) begin
      src_pulse = 6'($urandom);
      src_en = 6'($urandom);
      irq_mask = ($urandom % 4) == 0;
      fifo_nonempty = $urandom % 2;
      gpi_pending = $urandom % 2;
      wr_en = $urandom % 2;
      wr_data = 8'($urandom);
      if ((i % 300) == 299) rst = 1; else rst = 0;
      step();
    end
    rst = 0; idle(); step();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule